// File: doc/BRIEF.md
# Serial Bit-Step Shift Engine

This block is a multi-cycle shifter for a small datapath. It moves a data word one bit position per clock. It supports three operations: left logical, right logical and right arithmetic. A down-counter holds the number of steps still to run. A one-cycle start pulse captures the operation, the data word, the destination register index and a shift amount. The amount comes either from an immediate field or from a second register value.

The engine copies the operand unchanged into a working register and loads the counter. It then loops: each step shifts by one position and decrements the counter, until the counter reaches zero. At the end it issues a single-cycle done pulse together with a write strobe toward the destination register. A zero amount leaves early: done is pulsed and no write-back happens. Amounts are never clamped, so an amount of the data width or more simply runs that many steps.

Top module: `serial_shifter`

## Requirements
- R1: `op_i` encoding: 2'b00 selects the left logical shift. Each step moves the word one bit toward the MSB and inserts 0 at bit 0.
- R2: `op_i` = 2'b01 selects the right logical shift. Each step moves the word one bit toward the LSB and inserts 0 at the MSB.
- R3: `op_i` with bit 1 set (2'b10 or 2'b11) selects the right arithmetic shift. On every step the MSB is filled with the MSB of the operand as it was captured at start.
- R4: `amt_sel_i` = 0 takes the amount from `amt_imm_i`; `amt_sel_i` = 1 takes it from `amt_reg_i`. The unselected amount input has no effect. The register form adds exactly one cycle of latency.
- R5: For a nonzero amount N in immediate form, `done_o` is high N+2 clock edges after the edge that accepts the start. In register form it is high N+3 edges after that edge.
- R6: A zero amount raises `done_o` with `we_o` low, 1 edge after acceptance (immediate form) or 2 edges after (register form).
- R7: Amounts equal to or larger than DATA_W run that many steps. Logical shifts then give 0, and the arithmetic shift gives every bit equal to the captured sign bit.
- R8: `done_o` lasts exactly one cycle. For a nonzero amount, `we_o` is high in that same cycle, with `result_o` holding the shifted word and `dest_o` holding the index captured at start.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running operation finishes with its own operands, and no second operation follows.
- R10: `busy_o` is high from the cycle after an accepted start until the done cycle, in which it is low.
- R11: A synchronous active-low reset clears the counter, the working register (`result_o` reads 0), `busy_o`, `done_o` and `we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| op_i | input | 2 | Operation select (see R1 to R3) |
| amt_sel_i | input | 1 | Amount source: 0 immediate, 1 register |
| amt_imm_i | input | DATA_W | Immediate shift amount |
| amt_reg_i | input | DATA_W | Register-sourced shift amount |
| data_i | input | DATA_W | Operand to shift |
| dest_i | input | IDX_W | Destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| we_o | output | 1 | Destination write enable, only with done |
| dest_o | output | IDX_W | Destination index for the write |
| result_o | output | DATA_W | Working register / shifted result |

## Verification
The assertions assume that `rst_n` is driven low from time zero and that `start_i` is a clean synchronous level. They also assume that no operand is sampled except at an accepted start. The bench drives every input on the falling edge and asserts start for one cycle per operation. It issues stray starts only while the engine is busy, which is exactly the case R9 says must be ignored. Random amounts stay within 0 to DATA_W+4, so each run covers the unclamped overrun region and still finishes within a bounded loop. Directed cases add zero amounts, sign-fill edges and a mid-run reset.

// File: rtl/serial_shift_pkg.sv
// Package: shared types for the serial shift engine.
// Assumes: op encoding bit 1 = arithmetic right, else bit 0 picks direction.
package serial_shift_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CHECK = 3'd2,
        ST_STEP  = 3'd3,
        ST_WRITE = 3'd4
    } sh_state_e;

    localparam logic [1:0] OP_LEFT  = 2'b00;
    localparam logic [1:0] OP_RIGHT = 2'b01;

endpackage

// File: rtl/serial_shift_counter.sv
// Module: down-counter holding the remaining step count.
// Assumes: load has priority over decrement; decrement is never asked at zero.
module serial_shift_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: hold, load or decrement the remaining-step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
    assign last_o = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/serial_shift_datapath.sv
// Module: working register with one-bit-per-step shift and captured fill bit.
// Assumes: capture and step are never asserted in the same cycle.
module serial_shift_datapath
    import serial_shift_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] work_o
);
    logic [DATA_W-1:0] work_q;
    logic [DATA_W-1:0] to_left;
    logic [DATA_W-1:0] to_right;
    logic [1:0]        op_q;
    logic              sign_q;
    logic              fill_bit;

    // Purpose: choose the bit entering at the MSB on right steps.
    assign fill_bit = op_q[1] ? sign_q : 1'b0;

    // Per-bit neighbour selection for both directions.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign to_left[i] = 1'b0;
        end else begin : g_lsb_n
            assign to_left[i] = work_q[i-1];
        end
        if (i == DATA_W-1) begin : g_msb
            assign to_right[i] = fill_bit;
        end else begin : g_msb_n
            assign to_right[i] = work_q[i+1];
        end
    end

    // Purpose: capture operand, op and sign; then shift one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            op_q   <= OP_LEFT;
            sign_q <= 1'b0;
        end else if (capture_i) begin
            work_q <= data_i;
            op_q   <= op_i;
            sign_q <= data_i[DATA_W-1];
        end else if (step_i) begin
            work_q <= (op_q == OP_LEFT) ? to_left : to_right;
        end
    end

    assign work_o = work_q;
endmodule

// File: rtl/serial_shift_ctrl.sv
// Module: sequencer for fetch, zero test, step loop and write-back.
// Assumes: counter reports zero/last one cycle after its load.
module serial_shift_ctrl
    import serial_shift_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              amt_sel_i,
    input  logic [DATA_W-1:0] amt_imm_i,
    input  logic [DATA_W-1:0] amt_reg_i,
    input  logic [IDX_W-1:0]  dest_i,
    input  logic              cnt_zero_i,
    input  logic              cnt_last_i,
    output logic              cnt_load_o,
    output logic [DATA_W-1:0] cnt_val_o,
    output logic              cnt_dec_o,
    output logic              capture_o,
    output logic              step_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              we_o,
    output logic [IDX_W-1:0]  dest_o
);
    sh_state_e         state_q;
    logic [DATA_W-1:0] amt_hold_q;
    logic              accept;

    // Purpose: a start is taken only while idle.
    assign accept    = (state_q == ST_IDLE) && start_i;
    assign capture_o = accept;
    assign step_o    = (state_q == ST_STEP);
    assign cnt_dec_o = step_o;
    assign busy_o    = (state_q != ST_IDLE);

    // Purpose: counter load from immediate at accept or from held register amount.
    always_comb begin
        cnt_load_o = 1'b0;
        cnt_val_o  = amt_imm_i;
        if (accept && !amt_sel_i) begin
            cnt_load_o = 1'b1;
        end else if (state_q == ST_FETCH) begin
            cnt_load_o = 1'b1;
            cnt_val_o  = amt_hold_q;
        end
    end

    // Purpose: state sequencing and registered done / write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            amt_hold_q <= '0;
            dest_o     <= '0;
            done_o     <= 1'b0;
            we_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            we_o   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dest_o     <= dest_i;
                        amt_hold_q <= amt_reg_i;
                        state_q    <= amt_sel_i ? ST_FETCH : ST_CHECK;
                    end
                end
                ST_FETCH: state_q <= ST_CHECK;
                ST_CHECK: begin
                    if (cnt_zero_i) begin
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (cnt_last_i) state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    done_o  <= 1'b1;
                    we_o    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_shifter.sv
// Module: top of the serial shift engine.
// Assumes: start_i is a synchronous pulse; operands valid in the start cycle.
module serial_shifter #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              amt_sel_i,
    input  logic [DATA_W-1:0] amt_imm_i,
    input  logic [DATA_W-1:0] amt_reg_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  dest_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              we_o,
    output logic [IDX_W-1:0]  dest_o,
    output logic [DATA_W-1:0] result_o
);
    logic              cnt_load;
    logic [DATA_W-1:0] cnt_val;
    logic              cnt_dec;
    logic              cnt_zero;
    logic              cnt_last;
    logic              capture;
    logic              step;

    serial_shift_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .amt_sel_i(amt_sel_i),
        .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i), .dest_i(dest_i),
        .cnt_zero_i(cnt_zero), .cnt_last_i(cnt_last),
        .cnt_load_o(cnt_load), .cnt_val_o(cnt_val), .cnt_dec_o(cnt_dec),
        .capture_o(capture), .step_o(step), .busy_o(busy_o),
        .done_o(done_o), .we_o(we_o), .dest_o(dest_o)
    );

    serial_shift_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .load_val_i(cnt_val),
        .dec_i(cnt_dec), .zero_o(cnt_zero), .last_o(cnt_last)
    );

    serial_shift_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .op_i(op_i),
        .data_i(data_i), .step_i(step), .work_o(result_o)
    );
endmodule

// File: rtl/serial_shifter_chk.sv
// Module: protocol checker for the serial shift engine, bound to the top.
// Assumes: rst_n is low at time zero.
module serial_shifter_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              we_o,
    input logic [DATA_W-1:0] result_o
);
    AST_WE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) we_o |-> done_o); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o); // R10
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R10
    AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && !start_i) |=> $stable(result_o)); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!busy_o && !done_o && !we_o)); // R11
endmodule

bind serial_shifter serial_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .we_o(we_o), .result_o(result_o)
);

// File: tb/sim_serial_shifter.sv
module sim_serial_shifter;
    localparam int W  = 16;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic          amt_sel_i = 1'b0;
    logic [W-1:0]  amt_imm_i = '0;
    logic [W-1:0]  amt_reg_i = '0;
    logic [W-1:0]  data_i = '0;
    logic [IW-1:0] dest_i = '0;
    logic          busy_o, done_o, we_o;
    logic [IW-1:0] dest_o;
    logic [W-1:0]  result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    serial_shifter #(.DATA_W(W), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .amt_sel_i(amt_sel_i), .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i),
        .data_i(data_i), .dest_i(dest_i), .busy_o(busy_o), .done_o(done_o),
        .we_o(we_o), .dest_o(dest_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [1:0] op, input logic [W-1:0] d, input int n);
        logic [W-1:0] v = d;
        logic s = d[W-1];
        for (int i = 0; i < n; i++) begin
            if (op == 2'b00)      v = {v[W-2:0], 1'b0};
            else if (op == 2'b01) v = {1'b0, v[W-1:1]};
            else                  v = {s, v[W-1:1]};
        end
        return v;
    endfunction

    task automatic run(input logic [1:0] op, input bit sel, input logic [W-1:0] d,
                       input int amt, input logic [IW-1:0] dst, input bit inject);
        int lat = 0;
        int exp_lat;
        logic [W-1:0] expv;
        string rtag;
        @(negedge clk);
        start_i = 1'b1; op_i = op; amt_sel_i = sel; data_i = d; dest_i = dst;
        if (sel) begin amt_reg_i = W'(amt); amt_imm_i = W'($urandom_range(1, 40)); end
        else     begin amt_imm_i = W'(amt); amt_reg_i = W'($urandom_range(1, 40)); end
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10", "busy after accept", busy_o, 1);
        while (lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) break;
            if (inject && lat == 1) begin
                start_i = 1'b1; op_i = ~op; data_i = ~d; dest_i = ~dst;
                amt_imm_i = 3; amt_reg_i = 3;
            end
        end
        exp_lat = ((amt == 0) ? 1 : amt + 2) + (sel ? 1 : 0);
        if (amt == 0) begin
            chk(lat == exp_lat, "R6", "zero-amount latency", lat, exp_lat);
            chk(we_o == 1'b0, "R6", "no write for zero amount", we_o, 0);
        end else begin
            expv = model(op, d, amt);
            if (amt >= W) rtag = "R7";
            else if (op == 2'b00) rtag = "R1";
            else if (op == 2'b01) rtag = "R2";
            else rtag = "R3";
            chk(lat == exp_lat, sel ? "R4" : "R5", "latency", lat, exp_lat);
            chk(result_o == expv, rtag, "result", result_o, expv);
            chk(we_o == 1'b1, "R8", "write with done", we_o, 1);
            chk(dest_o == dst, "R8", "dest index", dest_o, dst);
            if (inject) chk(result_o == expv, "R9", "stray start ignored", result_o, expv);
        end
        chk(busy_o == 1'b0, "R10", "idle at done", busy_o, 0);
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0 && we_o == 1'b0, "R8", "done single cycle", {done_o, we_o}, 0);
        chk(busy_o == 1'b0, "R9", "no second op", busy_o, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy_o && !done_o && !we_o && result_o == 0, "R11", "reset state",
            {busy_o, done_o, we_o}, 0);
        rst_n = 1'b1;

        run(2'b00, 0, 16'h8001, 1, 5'd3, 0);
        run(2'b01, 0, 16'h8001, 1, 5'd4, 0);
        run(2'b10, 0, 16'h8001, 4, 5'd5, 0);
        run(2'b11, 0, 16'h4000, 3, 5'd6, 0);
        run(2'b00, 1, 16'h00ff, 5, 5'd7, 0);
        run(2'b10, 1, 16'hf00f, 2, 5'd8, 0);
        run(2'b01, 0, 16'h1234, 0, 5'd9, 0);
        run(2'b10, 1, 16'h8000, 0, 5'd10, 0);
        run(2'b00, 0, 16'hffff, 16, 5'd11, 0);
        run(2'b10, 0, 16'h8000, 20, 5'd12, 0);
        run(2'b01, 1, 16'hffff, 17, 5'd13, 0);
        run(2'b00, 0, 16'h0f0f, 6, 5'd14, 1);
        run(2'b10, 1, 16'h9999, 3, 5'd15, 1);

        for (int k = 0; k < 60; k++) begin
            run(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), W'($urandom),
                $urandom_range(0, W + 4), IW'($urandom), 1'($urandom_range(0, 1)));
        end

        // Mid-run reset: R11
        @(negedge clk);
        start_i = 1'b1; op_i = 2'b01; amt_sel_i = 0; amt_imm_i = 10; data_i = 16'hbeef;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !we_o, "R11", "reset mid-run flags", {busy_o, done_o, we_o}, 0);
        chk(result_o == 0, "R11", "reset clears work", result_o, 0);
        rst_n = 1'b1;
        run(2'b00, 0, 16'h0001, 15, 5'd1, 0);

        summary();
    end
endmodule